// File: doc/BRIEF.md
# Register-Select ALU Datapath Slice

This block is the combinational core of a small processor's execute stage. It receives the current contents of four 8-bit registers and a packed 9-bit instruction word. Two register fields choose the two operands. A 3-bit operation code picks one of eight results, which come from a shared add/subtract adder and a set of bitwise functions. A destination field sends that result to exactly one of four result ports.

The other result ports are driven to zero. A register file outside the block can therefore write back with an OR or a per-port write strobe and needs no decode of its own. The adder's carry-out is brought out on a separate pin. The block has no clock and holds no state.

Top module: `regsel_alu`

## Requirements
- R1: The instruction fields are opcode = instr_i[8:6], source A select = instr_i[5:4], source B select = instr_i[3:2], destination select = instr_i[1:0]. A select value k names regs_i[k] and results_o[k].
- R2: Operand A equals the register named by the source A field, and operand B equals the register named by the source B field. When both fields name the same register, both operands equal its value.
- R3: Opcode 000 yields A AND B, opcode 001 yields A OR B, and opcode 100 yields A XOR B, each bitwise over 8 bits.
- R4: Opcode 010 yields (A + B) mod 256, and carry_o is the ninth bit of A + B.
- R5: Opcode 011 yields (A − B) mod 256, and carry_o is the adder carry-out of A + ~B + 1. That carry is 1 exactly when A ≥ B as unsigned numbers.
- R6: Opcode 101 yields the bitwise NOT of A, and opcode 110 yields A unchanged.
- R7: Opcode 111 drives all four result ports to zero.
- R8: Every result port other than the one named by the destination field is zero.
- R9: carry_o is 0 for every opcode other than 010 and 011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| regs_i | input | 4x8 | Current register values, regs_i[k] is register k |
| instr_i | input | 9 | Packed opcode, source A, source B and destination fields |
| results_o | output | 4x8 | Result ports; only the destination port may be nonzero |
| carry_o | output | 1 | Adder carry-out for add and subtract, else 0 |

## Verification
The sweep drives all 512 instruction words against each of a set of register patterns. The patterns include all-zero, all-ones and sign-boundary values. Together they catch swapped or misplaced fields, a source multiplexer that confuses A with B when both name one register, a subtract that leaves out the +1 or inverts the carry, and a demultiplexer that leaks the result onto a second port. Carry is compared on every opcode, so a logic operation that lets the adder's carry through is reported. Opcode 111 is checked on every port to confirm that it clears the destination rather than passing an operand.

// File: rtl/regsel_alu_pkg.sv
package regsel_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND   = 3'b000,
    OP_OR    = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_XOR   = 3'b100,
    OP_NOTA  = 3'b101,
    OP_PASSA = 3'b110,
    OP_ZERO  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/operand_mux.sv
module operand_mux #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [SEL_W-1:0]                sel_i,
  output logic [DATA_W-1:0]               data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] gated;

  // AND-OR select: each register enabled by its own decode term
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_gate
    assign gated[i] = (sel_i == SEL_W'(i)) ? regs_i[i] : '0;
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) data_o = data_o | gated[i];
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import regsel_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic              sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;

  // one adder shared by add and subtract
  assign sub   = (op_i == OP_SUB);
  assign b_eff = sub ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};

  always_comb begin
    unique case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_ADD,
      OP_SUB:   res_o = sum[DATA_W-1:0];
      OP_XOR:   res_o = a_i ^ b_i;
      OP_NOTA:  res_o = ~a_i;
      OP_PASSA: res_o = a_i;
      default:  res_o = '0;
    endcase
  end

  assign carry_o = (op_i == OP_ADD || op_i == OP_SUB) ? sum[DATA_W] : 1'b0;
endmodule

// File: rtl/dest_demux.sv
module dest_demux #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0]               data_i,
  input  logic [SEL_W-1:0]                sel_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] results_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_port
    assign results_o[i] = (sel_i == SEL_W'(i)) ? data_i : '0;
  end
endmodule

// File: rtl/regsel_alu.sv
module regsel_alu
  import regsel_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int INSTR_W = OP_W + 3 * SEL_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [INSTR_W-1:0]              instr_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] results_o,
  output logic                            carry_o
);
  alu_op_e           op;
  logic [SEL_W-1:0]  src_a, src_b, dst;
  logic [DATA_W-1:0] opnd_a, opnd_b, alu_res;

  // field layout: opcode | src A | src B | dest
  assign op    = alu_op_e'(instr_i[INSTR_W-1 -: OP_W]);
  assign src_a = instr_i[3*SEL_W-1 -: SEL_W];
  assign src_b = instr_i[2*SEL_W-1 -: SEL_W];
  assign dst   = instr_i[SEL_W-1:0];

  operand_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_mux_a (
    .regs_i(regs_i), .sel_i(src_a), .data_o(opnd_a)
  );

  operand_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_mux_b (
    .regs_i(regs_i), .sel_i(src_b), .data_o(opnd_b)
  );

  alu_core #(.DATA_W(DATA_W)) u_alu (
    .a_i(opnd_a), .b_i(opnd_b), .op_i(op), .res_o(alu_res), .carry_o(carry_o)
  );

  dest_demux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_demux (
    .data_i(alu_res), .sel_i(dst), .results_o(results_o)
  );
endmodule

// File: rtl/regsel_alu_chk.sv
module regsel_alu_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int INSTR_W = 3 + 3 * SEL_W
) (
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input logic [INSTR_W-1:0]              instr_i,
  input logic [NUM_REGS-1:0][DATA_W-1:0] results_o,
  input logic                            carry_o
);
  logic [2:0]          c_op;
  logic [SEL_W-1:0]    c_sa, c_sb, c_dst;
  logic [NUM_REGS-1:0] nz;

  assign c_op  = instr_i[INSTR_W-1 -: 3];
  assign c_sa  = instr_i[3*SEL_W-1 -: SEL_W];
  assign c_sb  = instr_i[2*SEL_W-1 -: SEL_W];
  assign c_dst = instr_i[SEL_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_nz
    assign nz[i] = |results_o[i];
  end

  always_comb begin
    // R8
    single_dest_chk: assert ($onehot0(nz));
    for (int i = 0; i < NUM_REGS; i++) begin
      // R8
      idle_port_zero_chk: assert (SEL_W'(i) == c_dst || results_o[i] == '0);
      // R7
      zero_op_clear_chk: assert (c_op != 3'b111 || results_o[i] == '0);
    end
    // R9
    logic_no_carry_chk: assert (c_op == 3'b010 || c_op == 3'b011 || !carry_o);
    // R3
    and_result_chk: assert (c_op != 3'b000 ||
                            results_o[c_dst] == (regs_i[c_sa] & regs_i[c_sb]));
    // R6
    pass_a_chk: assert (c_op != 3'b110 || results_o[c_dst] == regs_i[c_sa]);
  end
endmodule

bind regsel_alu regsel_alu_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .regs_i(regs_i), .instr_i(instr_i), .results_o(results_o), .carry_o(carry_o)
);

// File: tb/tb_regsel_alu.sv
module tb_regsel_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0][7:0] regs;
  logic [8:0]      instr;
  logic [3:0][7:0] results;
  logic            carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  regsel_alu dut (.regs_i(regs), .instr_i(instr), .results_o(results), .carry_o(carry));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s instr=%h act=%h exp=%h", tag, instr, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] a, input logic [7:0] b,
                                input logic [2:0] op, output int r, output int c);
    c = 0;
    case (op)
      3'd0: r = a & b;
      3'd1: r = a | b;
      3'd2: begin r = (a + b) % 256; c = ((a + b) > 255) ? 1 : 0; end
      3'd3: begin r = (a - b + 256) % 256; c = (a >= b) ? 1 : 0; end
      3'd4: r = a ^ b;
      3'd5: r = 255 - a;
      3'd6: r = a;
      default: r = 0;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd4: return "R3";
      3'd2:             return "R4";
      3'd3:             return "R5";
      3'd5, 3'd6:       return "R6";
      default:          return "R7";
    endcase
  endfunction

  task automatic apply(input logic [8:0] ins);
    @(posedge clk);
    instr = ins;
    @(negedge clk);
  endtask

  initial begin
    int unsigned lfsr = 32'h1badf00d;
    int r, c;
    regs  = '0;
    instr = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // quiescent: zero registers, AND into port 0
    apply(9'd0);
    for (int p = 0; p < 4; p++) check("R8 idle", results[p], 0);
    check("R9 idle carry", carry, 0);

    // R1: pass A, srcA=3, srcB=0, dst=1
    regs = {8'h44, 8'h33, 8'h22, 8'h11};
    apply({3'b110, 2'd3, 2'd0, 2'd1});
    check("R1 dst port", results[1], 8'h44);
    check("R1 other port", results[3], 0);

    // R2: add with both sources = reg2
    apply({3'b010, 2'd2, 2'd2, 2'd0});
    check("R2 same src sum", results[0], 8'h66);

    // R5: subtract borrow case 0x11 - 0x22
    apply({3'b011, 2'd0, 2'd1, 2'd2});
    check("R5 sub value", results[2], 8'hEF);
    check("R5 sub carry", carry, 0);

    for (int pat = 0; pat < 18; pat++) begin
      case (pat)
        0: regs = '0;
        1: regs = '1;
        2: regs = {8'h80, 8'h7F, 8'h01, 8'hFF};
        3: regs = {8'h55, 8'hAA, 8'h0F, 8'hF0};
        default: begin
          for (int k = 0; k < 4; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            regs[k] = lfsr[7:0];
          end
        end
      endcase
      for (int ins = 0; ins < 512; ins++) begin
        logic [8:0] w;
        w = 9'(ins);
        apply(w);
        model(regs[w[5:4]], regs[w[3:2]], w[8:6], r, c);
        for (int p = 0; p < 4; p++) begin
          if (p == int'(w[1:0]))
            check(op_tag(w[8:6]), results[p], r);
          else
            check("R8", results[p], 0);
        end
        if (w[8:6] == 3'd2)      check("R4 carry", carry, c);
        else if (w[8:6] == 3'd3) check("R5 carry", carry, c);
        else                     check("R9 carry", carry, 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule